// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit up/down counter that produces centre-aligned, phase-correct PWM on two output channels. On each cycle where the timer-clock enable is high, the counter climbs to a TOP value, stays there for one step, falls back to zero, stays there for one step, and climbs again. The waveform-mode code selects the TOP source: one of three fixed ceilings (8, 9 or 10 bits), a period register, or the active compare value of channel A.

Each channel has a compare buffer that software writes at any time. The buffer moves into the active compare register only when the counter turns around at TOP, so a period is never cut short. A channel's output changes only on a compare match. The level it takes depends on the count direction and on the channel's output-mode code. Sticky flags record the bottom turnaround, the TOP turnaround in period-register mode, and compare matches. Software clears a flag by writing a 1 to it.

A single write port programs the control word, the period, the compare buffers and the flag clears. The block is meant to sit behind an external prescaler that supplies the enable.

Top module: `pc_pwm_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the counter to 0 and the direction to up. It clears every register and flag, and drives both PWM outputs to 0.
- R2: The write port decodes `wr_addr` as follows: 0 = control word, 1 = flag clear, 2 = period register, 3 = compare buffer A, 4 = compare buffer B. Control bits [3:0] hold the mode code: 1, 2 and 3 give a TOP of 0x00FF, 0x01FF and 0x03FF; 10 takes TOP from the period register; 11 takes TOP from the active compare A value. Any other mode code stops the timer, so the counter, the flags and the outputs hold.
- R3: Timer state changes only at edges where `tick` is high. Counting up, the counter adds one until it is at or above TOP. It then spends one step at that value and reverses. Counting down, it subtracts one until it reaches 0, spends one step at 0, and reverses again.
- R4: `flag_bottom` sets at every tick edge where the counter is 0 while counting down.
- R5: At each tick edge where the counter turns around at TOP, both active compare values load from their buffers. In the same edge, `flag_period` sets in mode 10, and `flag_cmp[0]` sets in mode 11.
- R6: `flag_cmp[i]` sets at any tick edge where the counter equals channel i's active compare value. A compare value above TOP therefore never sets the flag.
- R7: In modes 1, 2 and 3, a write to a compare buffer stores the written data with every bit above bit 7, 8 or 9 (respectively) forced to 0.
- R8: Channel i's output-mode code sits in control bits [5+2i:4+2i]. Code 2 (non-inverted): a match while counting up drives the output to 0, and a match while counting down drives it to 1. Code 3 (inverted) does the reverse. Codes 0 and 1 drive the output to 0. Without a match, the output holds.
- R9: Writing to address 1 clears each flag whose bit is 1: bit 0 clears bottom, bit 1 clears period, bit 2 clears compare A, bit 3 clears compare B. A clear takes effect on any edge. A set event at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm | output | 2 | PWM outputs, bit i = channel i |
| flag_bottom | output | 1 | Bottom turnaround flag |
| flag_period | output | 1 | TOP flag in period-register mode |
| flag_cmp | output | 2 | Compare-match flags, bit i = channel i |

## Verification
The hardest cases to reach from the ports are two:
- a flag clear landing on the very edge where the same flag sets;
- a TOP that falls below a channel's compare value, or below the current count.

To reach the first, the bench programs the minimum period of 3, so a turnaround and a match occur every few cycles. It then issues clear writes on every cycle for a long window, which guarantees collisions.

To reach the second, the bench switches modes while the counter sits at an arbitrary value. It then runs mode 11 with compare B above compare A, so that flag must stay clear after a reset of the flags. A behavioural model that tracks every register is compared on each cycle throughout.

// File: rtl/pc_pwm_pkg.sv
package pc_pwm_pkg;

    // waveform-mode codes
    localparam logic [3:0] MODE_FIX8   = 4'd1;
    localparam logic [3:0] MODE_FIX9   = 4'd2;
    localparam logic [3:0] MODE_FIX10  = 4'd3;
    localparam logic [3:0] MODE_PERIOD = 4'd10;
    localparam logic [3:0] MODE_CMPA   = 4'd11;

    // output-mode codes
    localparam logic [1:0] OUT_NONINV = 2'd2;
    localparam logic [1:0] OUT_INV    = 2'd3;

    // register addresses
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_FCLR   = 1;
    localparam int ADDR_PERIOD = 2;
    localparam int ADDR_CMP0   = 3;

    // flag-clear bit positions
    localparam int FBIT_BOTTOM = 0;
    localparam int FBIT_PERIOD = 1;
    localparam int FBIT_CMP0   = 2;

    // resolutions of the fixed ceilings
    localparam int FIX8_BITS  = 8;
    localparam int FIX9_BITS  = 9;
    localparam int FIX10_BITS = 10;

    // control word layout
    localparam int CTRL_MODE_W = 4;
    localparam int CTRL_OM_LSB = 4;

    function automatic logic mode_runs(input logic [3:0] m);
        return (m == MODE_FIX8) || (m == MODE_FIX9) || (m == MODE_FIX10) ||
               (m == MODE_PERIOD) || (m == MODE_CMPA);
    endfunction

endpackage

// File: rtl/pc_pwm_regs.sv
module pc_pwm_regs
    import pc_pwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2,
    parameter int AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [W-1:0]            wr_data,
    input  logic                    load_evt,
    output logic [3:0]              mode,
    output logic [NCH-1:0][1:0]     omode,
    output logic [W-1:0]            period,
    output logic [NCH-1:0][W-1:0]   cmp_act
);

    typedef struct packed {
        logic [3:0]            mode;
        logic [NCH-1:0][1:0]   omode;
        logic [W-1:0]          period;
        logic [NCH-1:0][W-1:0] cbuf;
        logic [NCH-1:0][W-1:0] cact;
    } regs_t;

    regs_t r_d, r_q;
    logic [W-1:0] wmask;

    always_comb begin
        case (r_q.mode)
            MODE_FIX8:  wmask = (W'(1) << FIX8_BITS) - W'(1);
            MODE_FIX9:  wmask = (W'(1) << FIX9_BITS) - W'(1);
            MODE_FIX10: wmask = (W'(1) << FIX10_BITS) - W'(1);
            default:    wmask = '1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        // double-buffer transfer uses the buffer as it stood before this edge
        if (load_evt) begin
            r_d.cact = r_q.cbuf;
        end
        if (wr_en) begin
            if (wr_addr == AW'(ADDR_CTRL)) begin
                r_d.mode = wr_data[CTRL_MODE_W-1:0];
                for (int i = 0; i < NCH; i++) begin
                    r_d.omode[i] = wr_data[CTRL_OM_LSB + 2*i +: 2];
                end
            end
            if (wr_addr == AW'(ADDR_PERIOD)) begin
                r_d.period = wr_data;
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(ADDR_CMP0 + i)) begin
                    r_d.cbuf[i] = wr_data & wmask;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mode    = r_q.mode;
    assign omode   = r_q.omode;
    assign period  = r_q.period;
    assign cmp_act = r_q.cact;

    // R5: active compares take the buffered values at the turnaround
    p_load_at_top_r5: assert property (@(posedge clk) disable iff (rst)
        load_evt |=> (r_q.cact == $past(r_q.cbuf)));

    // R7: an 8-bit-mode write leaves nothing above bit 7
    p_mask_fix8_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(ADDR_CMP0) && r_q.mode == MODE_FIX8)
        |=> ((r_q.cbuf[0] >> FIX8_BITS) == '0));

endmodule

// File: rtl/pc_pwm_counter.sv
module pc_pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         top_evt,
    output logic         bot_evt
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_t;

    cnt_t c_d, c_q;
    logic at_top, at_bot, step;

    assign step   = tick && run;
    assign at_top = !c_q.down && (c_q.cnt >= top);
    assign at_bot = c_q.down && (c_q.cnt == '0);

    always_comb begin
        c_d = c_q;
        if (step) begin
            if (at_top) begin
                c_d.down = 1'b1;
                if (c_q.cnt != '0) c_d.cnt = c_q.cnt - W'(1);
            end else if (at_bot) begin
                c_d.down = 1'b0;
                c_d.cnt  = c_q.cnt + W'(1);
            end else if (c_q.down) begin
                c_d.cnt = c_q.cnt - W'(1);
            end else begin
                c_d.cnt = c_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign cnt     = c_q.cnt;
    assign down    = c_q.down;
    assign top_evt = step && at_top;
    assign bot_evt = step && at_bot;

    // R3: no enabled step means no movement
    p_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(c_q.cnt) && $stable(c_q.down)));

    // R3: up-ramp below TOP advances by one
    p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !c_q.down && c_q.cnt < top) |=> (c_q.cnt == $past(c_q.cnt) + W'(1)));

endmodule

// File: rtl/pc_pwm_channel.sv
module pc_pwm_channel
    import pc_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   omode,
    output logic         match_evt,
    output logic         pwm
);

    typedef struct packed {
        logic pin;
    } ch_t;

    ch_t ch_d, ch_q;

    assign match_evt = step && (cnt == cmp);

    always_comb begin
        ch_d = ch_q;
        if (match_evt) begin
            case (omode)
                OUT_NONINV: ch_d.pin = down;
                OUT_INV:    ch_d.pin = !down;
                default:    ch_d.pin = ch_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign pwm = ((omode == OUT_NONINV) || (omode == OUT_INV)) ? ch_q.pin : 1'b0;

    // R8: pin register holds between matches
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !match_evt |=> $stable(ch_q.pin));

    // R8: non-inverted output follows direction at the match
    p_noninv_r8: assert property (@(posedge clk) disable iff (rst)
        (match_evt && omode == OUT_NONINV) |=> (ch_q.pin == $past(down)));

endmodule

// File: rtl/pc_pwm_timer.sv
module pc_pwm_timer
    import pc_pwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   count,
    output logic [NCH-1:0] pwm,
    output logic           flag_bottom,
    output logic           flag_period,
    output logic [NCH-1:0] flag_cmp
);

    typedef struct packed {
        logic           bottom;
        logic           period;
        logic [NCH-1:0] cmp;
    } flags_t;

    flags_t f_d, f_q;

    logic [3:0]            mode;
    logic [NCH-1:0][1:0]   omode;
    logic [W-1:0]          period;
    logic [NCH-1:0][W-1:0] cmp_act;
    logic [W-1:0]          top_val;
    logic [W-1:0]          cnt_w;
    logic                  down_w;
    logic                  run, step, top_evt, bot_evt;
    logic [NCH-1:0]        match_evt;
    logic [W-1:0]          clr;

    pc_pwm_regs #(.W(W), .NCH(NCH), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_evt (top_evt),
        .mode     (mode),
        .omode    (omode),
        .period   (period),
        .cmp_act  (cmp_act)
    );

    always_comb begin
        case (mode)
            MODE_FIX8:   top_val = (W'(1) << FIX8_BITS) - W'(1);
            MODE_FIX9:   top_val = (W'(1) << FIX9_BITS) - W'(1);
            MODE_FIX10:  top_val = (W'(1) << FIX10_BITS) - W'(1);
            MODE_PERIOD: top_val = period;
            MODE_CMPA:   top_val = cmp_act[0];
            default:     top_val = '1;
        endcase
    end

    assign run  = mode_runs(mode);
    assign step = tick && run;

    pc_pwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (run),
        .top     (top_val),
        .cnt     (cnt_w),
        .down    (down_w),
        .top_evt (top_evt),
        .bot_evt (bot_evt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pc_pwm_channel #(.W(W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .step      (step),
            .cnt       (cnt_w),
            .down      (down_w),
            .cmp       (cmp_act[i]),
            .omode     (omode[i]),
            .match_evt (match_evt[i]),
            .pwm       (pwm[i])
        );
    end

    assign clr = (wr_en && wr_addr == AW'(ADDR_FCLR)) ? wr_data : '0;

    always_comb begin
        f_d        = f_q;
        f_d.bottom = (f_q.bottom & !clr[FBIT_BOTTOM]) | bot_evt;
        f_d.period = (f_q.period & !clr[FBIT_PERIOD]) | (top_evt && mode == MODE_PERIOD);
        for (int i = 0; i < NCH; i++) begin
            f_d.cmp[i] = (f_q.cmp[i] & !clr[FBIT_CMP0 + i]) | match_evt[i] |
                         ((i == 0) && top_evt && mode == MODE_CMPA);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign count       = cnt_w;
    assign flag_bottom = f_q.bottom;
    assign flag_period = f_q.period;
    assign flag_cmp    = f_q.cmp;

    // R4: bottom turnaround raises the flag
    p_bottom_flag_r4: assert property (@(posedge clk) disable iff (rst)
        bot_evt |=> flag_bottom);

    // R5: TOP turnaround in period mode raises the period flag
    p_period_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (top_evt && mode == MODE_PERIOD) |=> flag_period);

    // R9: a clear without a coinciding set empties the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr[FBIT_BOTTOM] && !bot_evt) |=> !flag_bottom);

    // R2: a stopped mode freezes the count
    p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

endmodule

// File: tb/pc_pwm_timer_tb.sv
module pc_pwm_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic [1:0]  pwm;
    logic        flag_bottom, flag_period;
    logic [1:0]  flag_cmp;

    int checks = 0;
    int errors = 0;
    int peak   = 0;

    always #5 clk = ~clk;

    pc_pwm_timer u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .count       (count),
        .pwm         (pwm),
        .flag_bottom (flag_bottom),
        .flag_period (flag_period),
        .flag_cmp    (flag_cmp)
    );

    // ---------------- reference model ----------------
    int       m_cnt, m_per, m_mode;
    bit       m_down;
    int       m_om  [2];
    int       m_buf [2];
    int       m_act [2];
    bit       m_pin [2];
    bit [3:0] m_flags;

    always @(posedge clk) begin : model
        int       top, msk;
        bit       run, at_top, at_bot;
        bit [3:0] setv, clrv;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_mode = 0; m_down = 0; m_flags = '0;
            for (int c = 0; c < 2; c++) begin
                m_om[c] = 0; m_buf[c] = 0; m_act[c] = 0; m_pin[c] = 0;
            end
        end else begin
            case (m_mode)
                1: top = 255;
                2: top = 511;
                3: top = 1023;
                10: top = m_per;
                11: top = m_act[0];
                default: top = 65535;
            endcase
            run  = (m_mode inside {1, 2, 3, 10, 11});
            setv = '0;
            if (tick && run) begin
                at_top = !m_down && (m_cnt >= top);
                at_bot = m_down && (m_cnt == 0);
                for (int c = 0; c < 2; c++) begin
                    if (m_cnt == m_act[c]) begin
                        setv[2+c] = 1'b1;
                        if (m_om[c] == 2) m_pin[c] = m_down;
                        else if (m_om[c] == 3) m_pin[c] = !m_down;
                    end
                end
                if (at_bot) setv[0] = 1'b1;
                if (at_top) begin
                    if (m_mode == 10) setv[1] = 1'b1;
                    if (m_mode == 11) setv[2] = 1'b1;
                    m_act[0] = m_buf[0];
                    m_act[1] = m_buf[1];
                end
                if (at_top) begin
                    m_down = 1'b1;
                    if (m_cnt != 0) m_cnt = m_cnt - 1;
                end else if (at_bot) begin
                    m_down = 1'b0;
                    m_cnt  = m_cnt + 1;
                end else if (m_down) m_cnt = m_cnt - 1;
                else m_cnt = m_cnt + 1;
            end
            case (m_mode)
                1: msk = 16'h00FF;
                2: msk = 16'h01FF;
                3: msk = 16'h03FF;
                default: msk = 16'hFFFF;
            endcase
            clrv = '0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_mode = int'(wr_data[3:0]);
                        m_om[0] = int'(wr_data[5:4]);
                        m_om[1] = int'(wr_data[7:6]);
                    end
                    3'd1: clrv = wr_data[3:0];
                    3'd2: m_per = int'(wr_data);
                    3'd3: m_buf[0] = int'(wr_data) & msk;
                    3'd4: m_buf[1] = int'(wr_data) & msk;
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clrv) | setv;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_pwm(input int c);
        return (m_om[c] == 2 || m_om[c] == 3) ? int'(m_pin[c]) : 0;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 count", int'(count), m_cnt);
            chk("R4 flag_bottom", int'(flag_bottom), int'(m_flags[0]));
            chk("R5 flag_period", int'(flag_period), int'(m_flags[1]));
            chk("R6 flag_cmp A", int'(flag_cmp[0]), int'(m_flags[2]));
            chk("R6 flag_cmp B", int'(flag_cmp[1]), int'(m_flags[3]));
            chk("R8 pwm A", int'(pwm[0]), exp_pwm(0));
            chk("R8 pwm B", int'(pwm[1]), exp_pwm(1));
            if (int'(count) > peak) peak = int'(count);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cycles(input int n, input int gate);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (gate == 0) ? 1'b1 : ((i % gate) != 0);
        end
        @(negedge clk);
        tick = 1'b1;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(count), 0);
        chk("R1 pwm", int'(pwm), 0);
        chk("R1 flags", int'({flag_bottom, flag_period, flag_cmp}), 0);

        // R2 R8: 8-bit ceiling, non-inverted A, inverted B
        wr(3, 16'h0040);
        wr(4, 16'h0080);
        tick = 1'b1;
        wr(0, 1 | (2 << 4) | (3 << 6));
        peak = 0;
        run_cycles(1100, 0);
        chk("R2 peak 8-bit", peak, 255);

        // R3: gated enable
        run_cycles(400, 3);

        // R7: mask in 8-bit mode (0x1234 -> 0x34)
        wr(3, 16'h1234);
        run_cycles(700, 0);
        // R7: mask in 10-bit mode (0xFC80 -> 0x080)
        wr(0, 3 | (2 << 4) | (2 << 6));
        wr(4, 16'hFC80);
        peak = 0;
        run_cycles(2200, 0);
        chk("R2 peak 10-bit", peak, 1023);

        // R5 R9: minimum period with clear collisions
        wr(3, 1);
        wr(4, 2);
        wr(2, 3);
        wr(0, 10 | (3 << 4) | (2 << 6));
        run_cycles(60, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h000F;
        end
        @(negedge clk);
        wr_en = 1'b0;
        run_cycles(40, 0);

        // R6: compare A defines TOP, B above TOP never matches
        wr(3, 5);
        wr(4, 7);
        wr(0, 11 | (2 << 4) | (2 << 6));
        run_cycles(60, 0);
        wr(1, 16'h000F);
        run_cycles(200, 0);
        chk("R6 B above TOP", int'(flag_cmp[1]), 0);

        // R2: stopped mode holds; R9 clear while stopped
        wr(0, 0);
        held = int'(count);
        run_cycles(50, 0);
        chk("R2 stopped count", int'(count), held);
        wr(1, 16'h000F);
        chk("R9 cleared", int'({flag_bottom, flag_period, flag_cmp}), 0);

        // R2: 9-bit ceiling
        wr(0, 2 | (2 << 4) | (3 << 6));
        peak = 0;
        run_cycles(1100, 0);
        chk("R2 peak 9-bit", peak, 511);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule